// File: doc/BRIEF.md
# Flash Bank Access Router

The router sits between four flash read interfaces and the physical flash banks. It turns each read request into a request on one bank, together with the offset inside that bank. Each interface has a fixed address window. The upper bits of a request address pick a read port inside that window, and the router resolves the port to a bank from the live configuration. There are four code banks, numbered 0 to 3, and one data bank, numbered 4. The code banks form two halves: banks 0/1 and banks 2/3.

The primary interface serves CPU1 instruction fetch and data reads. The second CPU interface serves CPU3 and is live only in dual-CPU mode. The update interface reads the half of code flash that CPU1 is not executing from. The data interface always reaches the data bank. A per-CPU swap bit exchanges the roles of the two code halves, which makes a freshly programmed image visible to execution.

The router applies new configuration values only while it is idle. When two interfaces claim the same bank in the same cycle, a fixed priority decides. An illegal access returns an error pulse and touches no bank.

Top module: `flash_bank_router`

## Requirements
- R1: After synchronous reset, every `bank_vld` and `rsp_err` bit is low. The active configuration is single-CPU with both swap bits clear.
- R2: Port index = address bits [LOC_W+1:LOC_W], offset = bits [LOC_W-1:0], and the offset is passed unchanged to the bank. On the primary interface (index 0), ports 0/1 reach banks 0/1 when the CPU1 swap bit is clear and banks 2/3 when it is set. In single-CPU mode, ports 2/3 reach the opposite half. Both fetches and data reads are legal.
- R3: On the update interface (index 2), ports 0/1 reach banks 2/3 when the CPU1 swap bit is clear and banks 0/1 when it is set. A fetch, or port index 2 or 3, is illegal.
- R4: In single-CPU mode (`cfg_dual`=0), every request on the CPU3 interface (index 1) is illegal. In dual-CPU mode, ports 2/3 of the primary interface are illegal. CPU3 port k reaches bank h+(k XOR swap_c3), where h is 2 when the CPU1 swap bit is clear and 0 when it is set. CPU3 ports 2/3 are illegal.
- R5: On the data interface (index 3), port 0 with a data read reaches bank 4 under every configuration. A fetch or a nonzero port is illegal.
- R6: A request accepted at a clock edge (`req_vld` and `req_rdy` high) drives exactly one cycle of `bank_vld` on its bank after that edge. In that cycle `bank_addr` holds the offset and `bank_src` holds the 2-bit interface index.
- R7: An illegal request is accepted at once. It produces a one-cycle `rsp_err` pulse on its interface after that edge and no bank request.
- R8: When several legal requests target one bank in a cycle, the first in the order primary, CPU3, update, data is granted. Each loser sees `req_rdy` low, must hold its request, and is granted in a later cycle. At most one request reaches any bank per cycle.
- R9: New `cfg_dual`, `cfg_swap_c1` and `cfg_swap_c3` values are adopted only at an edge where no request is valid and no bank request or error is pending. Requests before that edge use the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 4 | Request valid, one bit per interface |
| req_fetch | input | 4 | 1 = instruction fetch, 0 = data read |
| req_addr | input | 4*(LOC_W+2) | Request addresses, interface i in slice i |
| req_rdy | output | 4 | Low only while a legal request is stalled by priority |
| rsp_err | output | 4 | One-cycle error response per interface |
| cfg_dual | input | 1 | Requested bank mode: 0 single CPU, 1 dual CPU |
| cfg_swap_c1 | input | 1 | Requested CPU1 swap bit |
| cfg_swap_c3 | input | 1 | Requested CPU3 swap bit |
| bank_vld | output | 5 | Bank request valid, banks 0 to 4 |
| bank_addr | output | 5*LOC_W | Offset inside each bank |
| bank_src | output | 10 | Originating interface index per bank |

## Verification
The bench builds the router with LOC_W=4, which gives a 6-bit window per interface. That width lets every offset boundary, including all-ones offsets, be driven next to each port index. It also keeps out-of-range port indices just one bit away from legal ones. With this width the bench covers every mode and swap combination, the priority collisions between all four interfaces, and the deferred adoption of configuration under back-to-back traffic.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int NIF    = 4;
    localparam int NBANK  = 5;
    localparam int BANK_W = $clog2(NBANK);
    localparam int SRC_W  = $clog2(NIF);
    localparam int PORT_W = 2;

    localparam int IF_MAIN = 0;
    localparam int IF_CPU3 = 1;
    localparam int IF_UPD  = 2;
    localparam int IF_DATA = 3;

    localparam logic [BANK_W-1:0] DATA_BANK = BANK_W'(4);

    typedef struct packed {
        logic dual;
        logic swap_c1;
        logic swap_c3;
    } fbr_cfg_t;

    typedef struct packed {
        logic              bad;
        logic [BANK_W-1:0] bank;
    } fbr_route_t;

    // Resolve one interface/port pair to a bank under a configuration.
    // Code bank index = {half, index-in-half}.
    function automatic fbr_route_t fbr_route(input int unsigned ifc,
                                             input logic [PORT_W-1:0] port,
                                             input logic fetch,
                                             input fbr_cfg_t c);
        fbr_route_t r;
        logic live_half;
        logic idle_half;
        live_half = c.swap_c1;
        idle_half = ~c.swap_c1;
        r.bad  = 1'b0;
        r.bank = '0;
        case (ifc)
            IF_MAIN: begin
                if (!port[1])
                    r.bank = {1'b0, live_half, port[0]};
                else if (!c.dual)
                    r.bank = {1'b0, idle_half, port[0]};
                else
                    r.bad = 1'b1;
            end
            IF_CPU3: begin
                if (!c.dual || port[1])
                    r.bad = 1'b1;
                else
                    r.bank = {1'b0, idle_half, port[0] ^ c.swap_c3};
            end
            IF_UPD: begin
                if (fetch || port[1])
                    r.bad = 1'b1;
                else
                    r.bank = {1'b0, idle_half, port[0]};
            end
            default: begin
                if (fetch || (port != '0))
                    r.bad = 1'b1;
                else
                    r.bank = DATA_BANK;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int LOC_W = 10,
    parameter int IFC   = 0
) (
    input  logic                    vld,
    input  logic                    fetch,
    input  logic [LOC_W+PORT_W-1:0] addr,
    input  fbr_cfg_t                cfg,
    output logic                    want,
    output logic                    bad,
    output logic [BANK_W-1:0]       bank,
    output logic [LOC_W-1:0]        ofs
);

    fbr_route_t r;

    always_comb begin
        r    = fbr_route(IFC, addr[LOC_W +: PORT_W], fetch, cfg);
        want = vld & ~r.bad;
        bad  = vld & r.bad;
        bank = r.bank;
        ofs  = addr[LOC_W-1:0];
    end

endmodule

// File: rtl/fbr_arbiter.sv
module fbr_arbiter
    import fbr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NIF-1:0]                 want,
    input  logic [NIF-1:0][BANK_W-1:0]     bank,
    output logic [NIF-1:0]                 grant
);

    // Lower index wins: a request is blocked by any earlier claimant of its bank.
    for (genvar i = 0; i < NIF; i++) begin : g_pri
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (want[j] && (bank[j] == bank[i]))
                    blocked = 1'b1;
            end
            grant[i] = want[i] & ~blocked;
        end

        for (genvar k = i + 1; k < NIF; k++) begin : g_pair
            a_r8_one_per_bank: assert property (@(posedge clk) disable iff (rst)
                (grant[i] && grant[k]) |-> (bank[i] != bank[k]));
        end
    end

    a_r8_primary_never_stalls: assert property (@(posedge clk) disable iff (rst)
        want[IF_MAIN] |-> grant[IF_MAIN]);

endmodule

// File: rtl/fbr_cfg.sv
module fbr_cfg
    import fbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  fbr_cfg_t nxt,
    output fbr_cfg_t act
);

    always_ff @(posedge clk) begin
        if (rst)
            act <= '0;
        else if (!busy)
            act <= nxt;
    end

    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(act));

endmodule

// File: rtl/flash_bank_router.sv
module flash_bank_router
    import fbr_pkg::*;
#(
    parameter int LOC_W = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NIF-1:0]               req_vld,
    input  logic [NIF-1:0]               req_fetch,
    input  logic [NIF*(LOC_W+PORT_W)-1:0] req_addr,
    output logic [NIF-1:0]               req_rdy,
    output logic [NIF-1:0]               rsp_err,
    input  logic                         cfg_dual,
    input  logic                         cfg_swap_c1,
    input  logic                         cfg_swap_c3,
    output logic [NBANK-1:0]             bank_vld,
    output logic [NBANK*LOC_W-1:0]       bank_addr,
    output logic [NBANK*SRC_W-1:0]       bank_src
);

    localparam int AW = LOC_W + PORT_W;

    fbr_cfg_t                     cfg_act;
    fbr_cfg_t                     cfg_nxt;
    logic                         busy;
    logic [NIF-1:0]               want;
    logic [NIF-1:0]               bad;
    logic [NIF-1:0]               grant;
    logic [NIF-1:0][BANK_W-1:0]   bank;
    logic [NIF-1:0][LOC_W-1:0]    ofs;

    logic [NBANK-1:0]             vld_q;
    logic [NBANK-1:0][LOC_W-1:0]  addr_q;
    logic [NBANK-1:0][SRC_W-1:0]  src_q;
    logic [NIF-1:0]               err_q;

    assign cfg_nxt = '{dual: cfg_dual, swap_c1: cfg_swap_c1, swap_c3: cfg_swap_c3};
    assign busy    = (|req_vld) | (|vld_q) | (|err_q);

    fbr_cfg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .nxt  (cfg_nxt),
        .act  (cfg_act)
    );

    for (genvar i = 0; i < NIF; i++) begin : g_dec
        fbr_decode #(.LOC_W(LOC_W), .IFC(i)) u_dec (
            .vld   (req_vld[i]),
            .fetch (req_fetch[i]),
            .addr  (req_addr[i*AW +: AW]),
            .cfg   (cfg_act),
            .want  (want[i]),
            .bad   (bad[i]),
            .bank  (bank[i]),
            .ofs   (ofs[i])
        );
        assign req_rdy[i] = ~(want[i] & ~grant[i]);
    end

    fbr_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .want  (want),
        .bank  (bank),
        .grant (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            err_q  <= '0;
        end else begin
            err_q <= bad;
            for (int b = 0; b < NBANK; b++) begin
                vld_q[b] <= 1'b0;
                for (int i = 0; i < NIF; i++) begin
                    if (grant[i] && (bank[i] == BANK_W'(b))) begin
                        vld_q[b]  <= 1'b1;
                        addr_q[b] <= ofs[i];
                        src_q[b]  <= SRC_W'(i);
                    end
                end
            end
        end
    end

    assign bank_vld  = vld_q;
    assign bank_addr = addr_q;
    assign bank_src  = src_q;
    assign rsp_err   = err_q;

    // R7: an error response never coincides with a bank request from the same interface.
    for (genvar i = 0; i < NIF; i++) begin : g_chk_err
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            a_r7_err_no_bank: assert property (@(posedge clk) disable iff (rst)
                rsp_err[i] |-> !(bank_vld[b] && (bank_src[b*SRC_W +: SRC_W] == SRC_W'(i))));
        end
    end

    a_r5_data_bank_owner: assert property (@(posedge clk) disable iff (rst)
        bank_vld[DATA_BANK] |-> (bank_src[int'(DATA_BANK)*SRC_W +: SRC_W] == SRC_W'(IF_DATA)));

    a_r6_grant_lands: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (|bank_vld));

    a_r7_bad_reports: assert property (@(posedge clk) disable iff (rst)
        (|bad) |=> (|rsp_err));

endmodule

// File: tb/sim_flash_bank_router.sv
`timescale 1ns/1ps
module sim_flash_bank_router;

    localparam int LW  = 4;
    localparam int AW  = LW + 2;
    localparam int NI  = 4;
    localparam int NB  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NI-1:0]     req_vld = '0;
    logic [NI-1:0]     req_fetch = '0;
    logic [NI*AW-1:0]  req_addr = '0;
    logic [NI-1:0]     req_rdy;
    logic [NI-1:0]     rsp_err;
    logic              cfg_dual = 1'b0;
    logic              cfg_swap_c1 = 1'b0;
    logic              cfg_swap_c3 = 1'b0;
    logic [NB-1:0]     bank_vld;
    logic [NB*LW-1:0]  bank_addr;
    logic [NB*2-1:0]   bank_src;

    flash_bank_router #(.LOC_W(LW)) u0 (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_fetch(req_fetch),
        .req_addr(req_addr), .req_rdy(req_rdy), .rsp_err(rsp_err),
        .cfg_dual(cfg_dual), .cfg_swap_c1(cfg_swap_c1), .cfg_swap_c3(cfg_swap_c3),
        .bank_vld(bank_vld), .bank_addr(bank_addr), .bank_src(bank_src)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    due;
        bit    err;
        int    ifc;
        int    bank;
        int    ofs;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    m_dual = 0, m_s1 = 0, m_s3 = 0;
    int    b_port[NI];
    int    b_ofs[NI];
    string b_tag[NI];

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // Bench-side routing model: -1 means illegal.
    function automatic int model(input int i, input int port, input bit fetch);
        int act_base  = m_s1 ? 2 : 0;
        int idle_base = 2 - act_base;
        case (i)
            0: begin
                if (port < 2) return act_base + port;
                if (!m_dual)  return idle_base + port - 2;
                return -1;
            end
            1: begin
                if (!m_dual || port > 1) return -1;
                return idle_base + (m_s3 ? 1 - port : port);
            end
            2: begin
                if (fetch || port > 1) return -1;
                return idle_base + port;
            end
            default: begin
                if (fetch || port != 0) return -1;
                return 4;
            end
        endcase
    endfunction

    task automatic put(input int i, input int port, input int ofs, input bit fetch, input string tag);
        req_vld[i] = 1'b1;
        req_fetch[i] = fetch;
        req_addr[i*AW +: AW] = AW'((port << LW) | ofs);
        b_port[i] = port;
        b_ofs[i]  = ofs;
        b_tag[i]  = tag;
    endtask

    // Driver: runs from a negedge, covers one clock edge, returns at the next negedge.
    task automatic tick();
        int eb[NI];
        bit acc[NI];
        #1;
        for (int i = 0; i < NI; i++) begin
            eb[i] = req_vld[i] ? model(i, b_port[i], req_fetch[i]) : -2;
            acc[i] = 0;
        end
        for (int i = 0; i < NI; i++) begin
            if (req_vld[i]) begin
                bit stall = 0;
                exp_t e;
                for (int j = 0; j < i; j++)
                    if (req_vld[j] && eb[i] >= 0 && eb[j] == eb[i]) stall = 1;
                check(req_rdy[i] == !stall, stall ? "R8" : b_tag[i], "req_rdy", int'(req_rdy[i]), int'(!stall));
                if (!stall) begin
                    acc[i] = 1;
                    e.due = cyc + 1; e.err = (eb[i] < 0); e.ifc = i;
                    e.bank = eb[i]; e.ofs = b_ofs[i]; e.tag = b_tag[i];
                    q.push_back(e);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NI; i++)
            if (acc[i]) req_vld[i] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic set_cfg(input bit d, input bit s1, input bit s3);
        cfg_dual = d; cfg_swap_c1 = s1; cfg_swap_c3 = s3;
        idle(3);
        m_dual = d; m_s1 = s1; m_s3 = s3;
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            for (int b = 0; b < NB; b++) begin
                if (bank_vld[b]) begin
                    int hit = -1;
                    for (int k = 0; k < q.size(); k++)
                        if (hit < 0 && q[k].due == cyc && !q[k].err && q[k].bank == b) hit = k;
                    if (hit < 0) begin
                        check(0, "R6", $sformatf("unexpected bank %0d request", b), 1, 0);
                    end else begin
                        check(int'(bank_addr[b*LW +: LW]) == q[hit].ofs, q[hit].tag,
                              $sformatf("bank %0d offset", b), int'(bank_addr[b*LW +: LW]), q[hit].ofs);
                        check(int'(bank_src[b*2 +: 2]) == q[hit].ifc, "R6",
                              $sformatf("bank %0d source", b), int'(bank_src[b*2 +: 2]), q[hit].ifc);
                        q.delete(hit);
                    end
                end
            end
            for (int i = 0; i < NI; i++) begin
                if (rsp_err[i]) begin
                    int hit = -1;
                    for (int k = 0; k < q.size(); k++)
                        if (hit < 0 && q[k].due == cyc && q[k].err && q[k].ifc == i) hit = k;
                    if (hit < 0) begin
                        check(0, "R7", $sformatf("unexpected error on interface %0d", i), 1, 0);
                    end else begin
                        check(1, q[hit].tag, "error", 1, 1);
                        q.delete(hit);
                    end
                end
            end
            for (int k = q.size() - 1; k >= 0; k--) begin
                if (q[k].due <= cyc) begin
                    check(0, q[k].tag, q[k].err ? $sformatf("missing error ifc %0d", q[k].ifc)
                                               : $sformatf("missing bank %0d request", q[k].bank),
                          0, 1);
                    q.delete(k);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(bank_vld == '0, "R1", "bank_vld after reset", int'(bank_vld), 0);
        check(rsp_err == '0, "R1", "rsp_err after reset", int'(rsp_err), 0);
        @(negedge clk);

        // R1/R2: defaults single-CPU, no swap; primary ports, boundary offsets
        put(0, 0, 0, 1, "R1"); tick();
        put(0, 1, 15, 0, "R2"); tick();
        put(0, 2, 7, 1, "R2"); tick();
        put(0, 3, 15, 0, "R2"); tick();
        // R3: update interface
        put(2, 0, 3, 0, "R3"); tick();
        put(2, 1, 12, 0, "R3"); tick();
        put(2, 0, 3, 1, "R3"); tick();
        put(2, 2, 0, 0, "R3"); tick();
        // R4: CPU3 disabled in single mode
        put(1, 0, 5, 1, "R4"); tick();
        // R5: data interface
        put(3, 0, 9, 0, "R5"); tick();
        put(3, 0, 9, 1, "R5"); tick();
        put(3, 1, 2, 0, "R5"); tick();
        // R6: back-to-back on distinct banks, all interfaces at once
        put(0, 0, 1, 0, "R6"); put(2, 1, 2, 0, "R6"); put(3, 0, 4, 0, "R6"); tick();
        idle(2);

        // R8: primary RP2 and update RP0 both hit bank 2
        put(0, 2, 5, 0, "R8"); put(2, 0, 9, 0, "R8"); tick();
        tick();
        idle(2);

        // Swap CPU1: halves exchange
        set_cfg(0, 1, 0);
        put(0, 0, 6, 1, "R2"); tick();
        put(0, 3, 8, 0, "R2"); tick();
        put(2, 0, 10, 0, "R3"); tick();
        put(2, 1, 11, 0, "R3"); tick();
        put(3, 0, 13, 0, "R5"); tick();

        // Dual mode
        set_cfg(1, 0, 0);
        put(1, 0, 1, 1, "R4"); tick();
        put(1, 1, 2, 0, "R4"); tick();
        put(1, 2, 2, 0, "R4"); tick();
        put(0, 2, 4, 0, "R4"); tick();
        put(0, 1, 4, 1, "R4"); tick();
        set_cfg(1, 0, 1);
        put(1, 0, 14, 1, "R4"); tick();
        put(1, 1, 15, 0, "R4"); tick();
        set_cfg(1, 1, 1);
        put(1, 0, 3, 0, "R4"); tick();
        put(0, 0, 3, 0, "R4"); tick();
        put(3, 0, 3, 0, "R5"); tick();

        // R8: four-way, CPU3 and update collide on bank 2
        set_cfg(1, 0, 0);
        put(0, 0, 1, 0, "R8"); put(1, 0, 2, 0, "R8"); put(2, 0, 3, 0, "R8"); put(3, 0, 4, 0, "R8");
        tick();
        tick();
        idle(2);

        // R9: configuration change held while traffic continues
        set_cfg(0, 0, 0);
        cfg_swap_c1 = 1'b1;
        put(0, 0, 2, 0, "R9"); tick();
        put(0, 0, 3, 0, "R9"); tick();
        put(0, 1, 4, 0, "R9"); tick();
        put(2, 0, 5, 0, "R9"); tick();
        idle(3);
        m_s1 = 1;
        put(0, 0, 6, 0, "R9"); tick();
        put(2, 0, 7, 0, "R9"); tick();
        idle(3);

        check(q.size() == 0, "R6", "scoreboard drained", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule